// File: doc/BRIEF.md
# Bus Master DMA Command and Status Registers

This block holds the software-visible control and status bytes for a two-channel bus master DMA engine that moves data between storage devices and system memory. Each channel has one command byte and one status byte on a small host I/O window. The command byte starts or stops the engine and selects the transfer direction. The status byte reports whether a transfer is running, whether the system bus returned an abort, and whether the device has raised its interrupt. It also holds two capability flags that only software reads.

The DMA engine, descriptor walking, the memory-side bus master and drive timing are outside the block. The block drives a start level, a direction level and a one-cycle abort pulse to the engine for each channel. It takes back an end-of-table completion pulse, a bus abort indication and the device interrupt line for each channel. Host reads return data one clock after the read strobe.

Top module: `bmdma_regs`

## Requirements
- R1: After a synchronous reset, every command and status byte reads 00h and the start, direction and abort outputs of every channel are 0.
- R2: Channel n's command byte is at offset n*8+0 and its status byte is at n*8+2. Read data appears on the read data port in the cycle after the read strobe. Every other offset reads 00h, and writes to it change nothing.
- R3: Command bit 0 drives the channel's start output (1 = run). Command bit 3 drives its direction output (0 = read from memory, 1 = write to memory). Command bits 7:4 and 2:1 read 0.
- R4: A write to command bit 3 is ignored while status bit 0 is 1. It takes effect again once status bit 0 has cleared, whether by stop or by end of table.
- R5: Status bit 0 sets when command bit 0 is written as 1. It clears when command bit 0 is written as 0, or on an end-of-table pulse while it is set. An end-of-table pulse leaves the start output unchanged.
- R6: Writing command bit 0 as 0 while status bit 0 is 1 and status bit 2 is 0 gives exactly one cycle of the channel's abort output. In every other case no abort pulse is produced.
- R7: Status bit 1 sets when the channel's bus abort input is high and is cleared by writing 1 to it. If both happen in the same cycle, the bit stays set.
- R8: Status bit 2 sets on a rising edge of the device interrupt line, detected against a copy registered every clock. It is cleared by writing 1 to it. After such a clear it stays 0 while the line remains high, and sets again only on a new rising edge. An edge in the same cycle as the clear leaves it set.
- R9: Status bits 6 and 5 are read/write flags for drive 1 and drive 0 and do not affect any output. Status bits 7, 4 and 3 read 0.
- R10: Writes to status bit 0 are ignored.
- R11: Accesses to one channel leave the other channel's bytes and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | Host I/O byte offset within the block |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Registered read data, valid the cycle after io_rd |
| eng_start | output | 2 | Per-channel run level to the DMA engine |
| eng_dir_wr | output | 2 | Per-channel direction, 1 = write to memory |
| eng_abort | output | 2 | Per-channel single-cycle abort pulse |
| eng_eot | input | 2 | Per-channel pulse: last end-of-table region done |
| bus_abort | input | 2 | Per-channel target or master abort on the system bus |
| dev_irq | input | 2 | Per-channel device interrupt line, already synchronous |

## Verification
The bench builds the block with its defaults: two channels and an eight-byte stride, which gives a four-bit offset. With these values every one of the sixteen offsets can be reached. That covers both register bytes of both channels and the unmapped holes inside each channel's window, so address misses and cross-channel leakage are both observable. Interrupt edges, bus aborts and end-of-table pulses are driven on a single channel while the other channel's bytes are read back. Same-cycle set-versus-clear collisions are driven on purpose.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  localparam int REG_W = 8;

  // byte offsets inside one channel window
  localparam int OFS_CMD = 0;
  localparam int OFS_STS = 2;

  // command byte fields
  localparam int CMD_GO_BIT  = 0;
  localparam int CMD_DIR_BIT = 3;

  // status byte fields
  localparam int STS_ACT_BIT  = 0;
  localparam int STS_ERR_BIT  = 1;
  localparam int STS_IRQ_BIT  = 2;
  localparam int STS_CAP0_BIT = 5;
  localparam int STS_CAP1_BIT = 6;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_STS  = 2'd2
  } regsel_e;

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
  import bmdma_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int STRIDE_LG = 3,
  parameter int CH_W      = 1,
  parameter int ADDR_W    = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [NUM_CH-1:0] cmd_wr_o,
  output logic [NUM_CH-1:0] sts_wr_o,
  output regsel_e           rd_sel_o,
  output logic [CH_W-1:0]   rd_ch_o
);

  logic [CH_W-1:0]      ch_idx;
  logic [STRIDE_LG-1:0] ofs;
  logic                 ch_ok;
  regsel_e              sel;

  assign ch_idx = addr_i[ADDR_W-1:STRIDE_LG];
  assign ofs    = addr_i[STRIDE_LG-1:0];
  assign ch_ok  = (int'(ch_idx) < NUM_CH);

  always_comb begin
    sel = SEL_NONE;
    if (ch_ok) begin
      if (ofs == STRIDE_LG'(OFS_CMD))      sel = SEL_CMD;
      else if (ofs == STRIDE_LG'(OFS_STS)) sel = SEL_STS;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
    assign cmd_wr_o[g] = wr_i && (sel == SEL_CMD) && (ch_idx == CH_W'(g));
    assign sts_wr_o[g] = wr_i && (sel == SEL_STS) && (ch_idx == CH_W'(g));
  end

  assign rd_sel_o = rd_i ? sel : SEL_NONE;
  assign rd_ch_o  = ch_idx;

endmodule

// File: rtl/bmdma_irq_edge.sv
module bmdma_irq_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= line_i;
  end

  assign rise_o = line_i & ~line_q;

endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr_i,
  input  logic             sts_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             eot_i,
  input  logic             bus_abort_i,
  input  logic             irq_rise_i,
  output logic [REG_W-1:0] cmd_o,
  output logic [REG_W-1:0] sts_o,
  output logic             start_o,
  output logic             dir_o,
  output logic             abort_o
);

  logic       start_q, dir_q, active_q, abort_q, err_q, irq_q;
  logic [1:0] cap_q;
  logic       go_bit, dir_bit, err_w1c, irq_w1c;
  logic       unused_wbits;

  assign go_bit  = wdata_i[CMD_GO_BIT];
  assign dir_bit = wdata_i[CMD_DIR_BIT];
  assign err_w1c = sts_wr_i && wdata_i[STS_ERR_BIT];
  assign irq_w1c = sts_wr_i && wdata_i[STS_IRQ_BIT];
  assign unused_wbits = ^{wdata_i[7], wdata_i[4], wdata_i[STS_ACT_BIT]};

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= 1'b0;
      dir_q    <= 1'b0;
      active_q <= 1'b0;
      abort_q  <= 1'b0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
      cap_q    <= 2'b00;
    end else begin
      abort_q <= 1'b0;
      if (cmd_wr_i) begin
        start_q <= go_bit;
        if (!active_q) dir_q <= dir_bit;
        if (go_bit) begin
          active_q <= 1'b1;
        end else begin
          active_q <= 1'b0;
          if (active_q && !irq_q) abort_q <= 1'b1;
        end
      end else if (eot_i && active_q) begin
        active_q <= 1'b0;
      end
      // setting condition has priority over the software clear
      if (bus_abort_i)  err_q <= 1'b1;
      else if (err_w1c) err_q <= 1'b0;
      if (irq_rise_i)   irq_q <= 1'b1;
      else if (irq_w1c) irq_q <= 1'b0;
      if (sts_wr_i) cap_q <= {wdata_i[STS_CAP1_BIT], wdata_i[STS_CAP0_BIT]};
    end
  end

  assign cmd_o   = {4'b0000, dir_q, 2'b00, start_q};
  assign sts_o   = {1'b0, cap_q[1], cap_q[0], 2'b00, irq_q, err_q, active_q};
  assign start_o = start_q;
  assign dir_o   = dir_q;
  assign abort_o = abort_q;

  // R4
  dir_locked_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |=> $stable(dir_q));

  // R5
  act_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(active_q) |-> $past(eot_i || (cmd_wr_i && !go_bit)));

  // R5
  act_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |-> start_q);

  // R6
  abort_single_chk: assert property (@(posedge clk) disable iff (rst)
    abort_q |=> !abort_q);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(bus_abort_i));

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(irq_rise_i));

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter  int NUM_CH    = 2,
  parameter  int STRIDE_LG = 3,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W    = STRIDE_LG + CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [REG_W-1:0]  io_wdata,
  output logic [REG_W-1:0]  io_rdata,
  output logic [NUM_CH-1:0] eng_start,
  output logic [NUM_CH-1:0] eng_dir_wr,
  output logic [NUM_CH-1:0] eng_abort,
  input  logic [NUM_CH-1:0] eng_eot,
  input  logic [NUM_CH-1:0] bus_abort,
  input  logic [NUM_CH-1:0] dev_irq
);

  logic [NUM_CH-1:0] cmd_wr, sts_wr, irq_rise;
  regsel_e           rd_sel;
  logic [CH_W-1:0]   rd_ch;
  logic [REG_W-1:0]  cmd_bus [NUM_CH];
  logic [REG_W-1:0]  sts_bus [NUM_CH];
  logic [REG_W-1:0]  rd_word;

  bmdma_decode #(
    .NUM_CH(NUM_CH), .STRIDE_LG(STRIDE_LG), .CH_W(CH_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .addr_i  (io_addr),
    .wr_i    (io_wr),
    .rd_i    (io_rd),
    .cmd_wr_o(cmd_wr),
    .sts_wr_o(sts_wr),
    .rd_sel_o(rd_sel),
    .rd_ch_o (rd_ch)
  );

  bmdma_irq_edge #(.W(NUM_CH)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .line_i(dev_irq),
    .rise_o(irq_rise)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bmdma_chan u_chan (
      .clk        (clk),
      .rst        (rst),
      .cmd_wr_i   (cmd_wr[c]),
      .sts_wr_i   (sts_wr[c]),
      .wdata_i    (io_wdata),
      .eot_i      (eng_eot[c]),
      .bus_abort_i(bus_abort[c]),
      .irq_rise_i (irq_rise[c]),
      .cmd_o      (cmd_bus[c]),
      .sts_o      (sts_bus[c]),
      .start_o    (eng_start[c]),
      .dir_o      (eng_dir_wr[c]),
      .abort_o    (eng_abort[c])
    );
  end

  always_comb begin
    case (rd_sel)
      SEL_CMD: rd_word = cmd_bus[rd_ch];
      SEL_STS: rd_word = sts_bus[rd_ch];
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) io_rdata <= '0;
    else     io_rdata <= rd_word;
  end

  // R9
  sts_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_sel == SEL_STS) |-> (io_rdata[7] == 1'b0 && io_rdata[4:3] == 2'b00));

  // R3
  cmd_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_sel == SEL_CMD) |-> (io_rdata[7:4] == 4'h0 && io_rdata[2:1] == 2'b00));

endmodule

// File: tb/bmdma_regs_tb.sv
module bmdma_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 32;

  typedef struct packed {
    logic [23:0] tag;
    logic        is_wr;
    logic [3:0]  addr;
    logic [7:0]  data;   // write data, or expected read data
  } vec_t;

  // walked in order; state carries from row to row
  localparam vec_t VECS [NV] = '{
    '{"R1 ", 1'b0, 4'h0, 8'h00},
    '{"R1 ", 1'b0, 4'h2, 8'h00},
    '{"R1 ", 1'b0, 4'h8, 8'h00},
    '{"R1 ", 1'b0, 4'hA, 8'h00},
    '{"R3 ", 1'b1, 4'h0, 8'hF9},   // start, write dir, reserved ones
    '{"R3 ", 1'b0, 4'h0, 8'h09},
    '{"R5 ", 1'b0, 4'h2, 8'h01},
    '{"R4 ", 1'b1, 4'h0, 8'h01},   // try dir=0 while running
    '{"R4 ", 1'b0, 4'h0, 8'h09},
    '{"R9 ", 1'b1, 4'h2, 8'h61},
    '{"R9 ", 1'b0, 4'h2, 8'h61},
    '{"R11", 1'b0, 4'h8, 8'h00},
    '{"R5 ", 1'b1, 4'h0, 8'h00},   // stop, dir still locked in this write
    '{"R4 ", 1'b0, 4'h0, 8'h08},
    '{"R5 ", 1'b0, 4'h2, 8'h60},
    '{"R10", 1'b1, 4'h2, 8'h61},
    '{"R10", 1'b0, 4'h2, 8'h60},
    '{"R4 ", 1'b1, 4'h0, 8'h00},
    '{"R4 ", 1'b0, 4'h0, 8'h00},
    '{"R2 ", 1'b1, 4'h4, 8'hFF},
    '{"R2 ", 1'b0, 4'h4, 8'h00},
    '{"R2 ", 1'b0, 4'h0, 8'h00},
    '{"R2 ", 1'b1, 4'hE, 8'hFF},
    '{"R2 ", 1'b0, 4'hE, 8'h00},
    '{"R2 ", 1'b0, 4'h1, 8'h00},
    '{"R9 ", 1'b1, 4'h8, 8'hFF},
    '{"R9 ", 1'b0, 4'h8, 8'h09},
    '{"R11", 1'b0, 4'hA, 8'h01},
    '{"R11", 1'b0, 4'h2, 8'h60},
    '{"R10", 1'b1, 4'hA, 8'hFF},
    '{"R10", 1'b0, 4'hA, 8'h61},
    '{"R11", 1'b0, 4'h0, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] io_addr = '0;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [1:0] eng_start, eng_dir_wr, eng_abort;
  logic [1:0] eng_eot = '0, bus_abort = '0, dev_irq = '0;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmdma_regs dut_i (
    .clk(clk), .rst(rst),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .eng_start(eng_start), .eng_dir_wr(eng_dir_wr), .eng_abort(eng_abort),
    .eng_eot(eng_eot), .bus_abort(bus_abort), .dev_irq(dev_irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    tick();
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    io_addr = a; io_rd = 1'b1;
    tick();
    io_rd = 1'b0;
    chk(tag, io_rdata, exp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1", {6'd0, eng_start},  8'h00);
    chk("R1", {6'd0, eng_dir_wr}, 8'h00);
    chk("R1", {6'd0, eng_abort},  8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_wr) wr(VECS[i].addr, VECS[i].data);
      else               rd(VECS[i].addr, VECS[i].data, string'(VECS[i].tag));
    end

    // directed section from a clean state
    do_reset();
    rd(4'h2, 8'h00, "R1");

    // R3 engine outputs follow the command byte
    wr(4'h0, 8'h09);
    chk("R3", {7'd0, eng_start[0]},  8'h01);
    chk("R3", {7'd0, eng_dir_wr[0]}, 8'h01);
    chk("R11", {6'd0, eng_start[1], eng_dir_wr[1]}, 8'h00);
    // R6 stop while running and no interrupt: one-cycle abort
    wr(4'h0, 8'h00);
    chk("R6", {6'd0, eng_abort}, 8'h01);
    tick();
    chk("R6", {6'd0, eng_abort}, 8'h00);
    // R6 stop while idle: no pulse
    wr(4'h0, 8'h00);
    chk("R6", {6'd0, eng_abort}, 8'h00);

    // R6 stop after device interrupt: no pulse
    wr(4'h0, 8'h01);
    dev_irq[0] = 1'b1;
    tick();
    rd(4'h2, 8'h05, "R8");
    wr(4'h0, 8'h00);
    chk("R6", {6'd0, eng_abort}, 8'h00);
    rd(4'h2, 8'h04, "R5");
    // R8 clear while line high stays clear
    wr(4'h2, 8'h04);
    rd(4'h2, 8'h00, "R8");
    tick(); tick(); tick();
    rd(4'h2, 8'h00, "R8");
    dev_irq[0] = 1'b0;
    tick();
    dev_irq[0] = 1'b1;
    tick();
    rd(4'h2, 8'h04, "R8");
    dev_irq[0] = 1'b0;
    wr(4'h2, 8'h04);
    rd(4'h2, 8'h00, "R8");
    // R8 edge and clear in one cycle: edge wins
    dev_irq[0] = 1'b1;
    wr(4'h2, 8'h04);
    rd(4'h2, 8'h04, "R8");
    dev_irq[0] = 1'b0;
    wr(4'h2, 8'h04);
    rd(4'h2, 8'h00, "R8");

    // R5 end of table clears active, start held
    wr(4'h0, 8'h09);
    eng_eot[0] = 1'b1;
    tick();
    eng_eot[0] = 1'b0;
    rd(4'h2, 8'h00, "R5");
    chk("R5", {7'd0, eng_start[0]}, 8'h01);
    // R4 direction writable again after end of table
    wr(4'h0, 8'h01);
    chk("R4", {7'd0, eng_dir_wr[0]}, 8'h00);
    rd(4'h2, 8'h01, "R5");
    eng_eot[0] = 1'b1;
    tick();
    eng_eot[0] = 1'b0;
    wr(4'h0, 8'h00);
    chk("R6", {6'd0, eng_abort}, 8'h00);

    // R7 bus abort sets error, write-one clears, set wins on collision
    bus_abort[0] = 1'b1;
    tick();
    bus_abort[0] = 1'b0;
    rd(4'h2, 8'h02, "R7");
    wr(4'h2, 8'h02);
    rd(4'h2, 8'h00, "R7");
    bus_abort[0] = 1'b1;
    wr(4'h2, 8'h02);
    bus_abort[0] = 1'b0;
    rd(4'h2, 8'h02, "R7");
    wr(4'h2, 8'h02);
    rd(4'h2, 8'h00, "R7");

    // R11 events on channel 1 only
    bus_abort[1] = 1'b1;
    tick();
    bus_abort[1] = 1'b0;
    rd(4'h2, 8'h00, "R11");
    rd(4'hA, 8'h02, "R11");

    // R9 capability flags do not touch engine outputs
    wr(4'h0, 8'h09);
    wr(4'h2, 8'h60);
    chk("R9", {7'd0, eng_start[0]},  8'h01);
    chk("R9", {7'd0, eng_dir_wr[0]}, 8'h01);
    chk("R9", {6'd0, eng_abort},     8'h00);
    rd(4'h2, 8'h61, "R9");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule